// File: doc/BRIEF.md
# Packed Pixel Arithmetic Unit

This block processes 8-bit grayscale pixels packed four to a 32-bit word. A host pushes words in with a one-cycle write strobe. A mode input selects one of three operations. Brightness adds a signed constant to every pixel. Blend adds pixels from two images. Fade mixes two images by a fraction. In every mode, results that leave the 0..255 range are clamped.

In the two-source modes each input word carries two pixels from each image, so it yields only two result pixels. The unit holds the first half-word of results. It releases a full four-pixel word after every second write, so the host reads whole words only. The host prepares the interleaved input words. A change of mode throws away a half-filled result word.

Top module: `pixel_pack_alu`

## Requirements
- R1: While reset is active and on the first cycle after it, `rdValid` is 0 and `rdData` is 0.
- R2: Brightness (mode code 0). A write produces, one cycle later, a word whose byte i is clamp(pixel_i + brightK) to 0..255. `brightK` is a signed 9-bit two's-complement value, and byte i is bits [8i+7:8i]. `rdValid` pulses for that cycle.
- R3: Blend (mode code 1). The input layout is [31:24]=A1, [23:16]=B1, [15:8]=A0, [7:0]=B0. Each pair gives min(A+B, 255).
- R4: Fade (mode code 2), same layout as R3. Each pair gives clamp(B + floor((A−B)×f/256)) to 0..255, where f is the unsigned 8-bit `fadeF`.
- R5: In the two-source modes the first write's results fill bits [15:0] (pair 0 in [7:0], pair 1 in [15:8]). The second write's results fill [31:16] in the same order. `rdValid` pulses only one cycle after every second write.
- R6: A cycle in which `modeSel` differs from its value in the previous cycle discards any half-filled result. The next two-source write then counts as a first write.
- R7: Without a write, `rdValid` stays 0 and `rdData` holds its value. Writes with mode code 3 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrStb | input | 1 | One-cycle write strobe |
| wrData | input | 32 | Packed input pixels |
| modeSel | input | 2 | 0 brightness, 1 blend, 2 fade, 3 ignored |
| brightK | input | 9 | Signed brightness constant |
| fadeF | input | 8 | Fade fraction f/256 |
| rdData | output | 32 | Packed result word |
| rdValid | output | 1 | One-cycle pulse when a new result word is ready |

## Verification
The bench drives brightness constants at both extremes and both sides of zero, so that both clamps are hit. A design that wrapped instead of clamping, or that treated the constant as unsigned, would return small values where 255 or 0 is due. Fade is checked with f of 0, 128 and 255, and with A below B. A design that shifted logically, or that truncated toward zero, would be off by one or badly wrong on negative differences. The bench also checks that no word appears after a single two-source write, that the half-words come out in the right order, and that a mode switch discards a stale half. A design that ignored the switch would release a word that mixes results from two modes.

// File: rtl/pxpkg.sv
package pxpkg;
  localparam int PIX_W = 8;
  localparam int LANES = 4;
  localparam int WORD_W = PIX_W * LANES;
  localparam int PAIRS = LANES / 2;
  localparam int HALF_W = WORD_W / 2;
  localparam int K_W = PIX_W + 1;
  localparam int F_W = PIX_W;

  typedef enum logic [1:0] {
    MODE_BRIGHT = 2'd0,
    MODE_BLEND  = 2'd1,
    MODE_FADE   = 2'd2,
    MODE_NONE   = 2'd3
  } modeT;

  typedef struct packed {
    logic loadLow;
    logic emitBright;
    logic emitPair;
    logic useFade;
  } ctlT;
endpackage

// File: rtl/px_bright_lane.sv
module px_bright_lane
  import pxpkg::*;
(
  input  logic [PIX_W-1:0]     pix,
  input  logic signed [K_W-1:0] kVal,
  output logic [PIX_W-1:0]     res
);
  localparam int SUM_W = PIX_W + 2;
  localparam int MAXV = (1 << PIX_W) - 1;
  logic signed [SUM_W-1:0] sum;

  always_comb begin
    sum = $signed({2'b00, pix}) + SUM_W'(kVal);
    if (sum < 0)
      res = '0;
    else if (sum > SUM_W'(MAXV))
      res = PIX_W'(MAXV);
    else
      res = sum[PIX_W-1:0];
  end
endmodule

// File: rtl/px_pair_lane.sv
module px_pair_lane
  import pxpkg::*;
(
  input  logic [PIX_W-1:0] pixA,
  input  logic [PIX_W-1:0] pixB,
  input  logic [F_W-1:0]   fVal,
  input  logic             useFade,
  output logic [PIX_W-1:0] res
);
  localparam int PW = PIX_W + F_W + 2;
  localparam int MAXV = (1 << PIX_W) - 1;
  logic signed [PW-1:0] diff, prod, scaled, mix;
  logic [PIX_W:0] addSum;

  always_comb begin
    addSum = {1'b0, pixA} + {1'b0, pixB};
    diff   = $signed(PW'(pixA)) - $signed(PW'(pixB));
    prod   = diff * $signed(PW'(fVal));
    scaled = prod >>> F_W;
    mix    = $signed(PW'(pixB)) + scaled;
    if (useFade) begin
      if (mix < 0)
        res = '0;
      else if (mix > PW'(MAXV))
        res = PIX_W'(MAXV);
      else
        res = mix[PIX_W-1:0];
    end else begin
      res = addSum[PIX_W] ? PIX_W'(MAXV) : addSum[PIX_W-1:0];
    end
  end
endmodule

// File: rtl/px_control.sv
module px_control
  import pxpkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrStb,
  input  logic [1:0] modeSel,
  output ctlT        ctl
);
  logic halfFull;
  modeT lastMode;
  modeT curMode;
  logic modeChg, twoSrc, effHalf;

  always_comb begin
    curMode = modeT'(modeSel);
    modeChg = (curMode != lastMode);
    twoSrc  = (curMode == MODE_BLEND) || (curMode == MODE_FADE);
    effHalf = halfFull && !modeChg;
    ctl.useFade    = (curMode == MODE_FADE);
    ctl.emitBright = wrStb && (curMode == MODE_BRIGHT);
    ctl.loadLow    = wrStb && twoSrc && !effHalf;
    ctl.emitPair   = wrStb && twoSrc && effHalf;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      halfFull <= 1'b0;
      lastMode <= MODE_BRIGHT;
    end else begin
      lastMode <= curMode;
      if (ctl.loadLow)
        halfFull <= 1'b1;
      else if (ctl.emitPair || modeChg)
        halfFull <= 1'b0;
    end
  end

  assert_one_action_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.loadLow, ctl.emitBright, ctl.emitPair}));
  assert_pair_drains_half_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.emitPair |=> !halfFull);
  assert_switch_drops_half_R6: assert property (@(posedge clk) disable iff (!rstN)
    (modeChg && !wrStb) |=> !halfFull);
endmodule

// File: rtl/px_datapath.sv
module px_datapath
  import pxpkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlT               ctl,
  input  logic [WORD_W-1:0] wrData,
  input  logic [K_W-1:0]    brightK,
  input  logic [F_W-1:0]    fadeF,
  output logic [WORD_W-1:0] rdData,
  output logic              rdValid
);
  logic [WORD_W-1:0] brightWord;
  logic [HALF_W-1:0] pairHalf;
  logic [HALF_W-1:0] halfReg;

  for (genvar i = 0; i < LANES; i++) begin : g_bright
    px_bright_lane u_lane (
      .pix  (wrData[i*PIX_W +: PIX_W]),
      .kVal ($signed(brightK)),
      .res  (brightWord[i*PIX_W +: PIX_W])
    );
  end

  for (genvar j = 0; j < PAIRS; j++) begin : g_pair
    px_pair_lane u_lane (
      .pixA    (wrData[(2*j+1)*PIX_W +: PIX_W]),
      .pixB    (wrData[(2*j)*PIX_W +: PIX_W]),
      .fVal    (fadeF),
      .useFade (ctl.useFade),
      .res     (pairHalf[j*PIX_W +: PIX_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      halfReg <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= ctl.emitBright || ctl.emitPair;
      if (ctl.loadLow)
        halfReg <= pairHalf;
      if (ctl.emitBright)
        rdData <= brightWord;
      else if (ctl.emitPair)
        rdData <= {pairHalf, halfReg};
    end
  end

  assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.emitBright || ctl.emitPair) |=> $stable(rdData));
endmodule

// File: rtl/pixel_pack_alu.sv
module pixel_pack_alu
  import pxpkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStb,
  input  logic [WORD_W-1:0] wrData,
  input  logic [1:0]        modeSel,
  input  logic [K_W-1:0]    brightK,
  input  logic [F_W-1:0]    fadeF,
  output logic [WORD_W-1:0] rdData,
  output logic              rdValid
);
  ctlT ctl;

  px_control u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .wrStb   (wrStb),
    .modeSel (modeSel),
    .ctl     (ctl)
  );

  px_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .wrData  (wrData),
    .brightK (brightK),
    .fadeF   (fadeF),
    .rdData  (rdData),
    .rdValid (rdValid)
  );

  assert_no_valid_without_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    !wrStb |=> !rdValid);
  assert_ignored_mode_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb && modeSel == 2'd3) |=> !rdValid);
endmodule

// File: tb/test_pixel_pack_alu.sv
module test_pixel_pack_alu;
  localparam int CLK_PERIOD = 10;

  logic clk = 0;
  logic rstN = 0;
  logic wrStb = 0;
  logic [31:0] wrData = '0;
  logic [1:0] modeSel = 2'd0;
  logic [8:0] brightK = '0;
  logic [7:0] fadeF = '0;
  logic [31:0] rdData;
  logic rdValid;
  int nChecks = 0;
  int nFails = 0;

  pixel_pack_alu i_pixel_pack_alu (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .wrData(wrData), .modeSel(modeSel),
    .brightK(brightK), .fadeF(fadeF), .rdData(rdData), .rdValid(rdValid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] clampPix(int v);
    return (v < 0) ? 8'd0 : (v > 255) ? 8'd255 : v[7:0];
  endfunction

  function automatic logic [7:0] brightRef(logic [7:0] p, logic signed [8:0] k);
    return clampPix(int'(p) + int'(k));
  endfunction

  function automatic logic [7:0] pairRef(logic [7:0] a, logic [7:0] b, bit fade, logic [7:0] f);
    int d;
    if (!fade) return clampPix(int'(a) + int'(b));
    d = (int'(a) - int'(b)) * int'(f);
    return clampPix(int'(b) + (d >>> 8));
  endfunction

  function automatic logic [15:0] halfRef(logic [31:0] w, bit fade, logic [7:0] f);
    return {pairRef(w[31:24], w[23:16], fade, f), pairRef(w[15:8], w[7:0], fade, f)};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(logic [31:0] d);
    @(negedge clk);
    wrData = d; wrStb = 1'b1;
    @(negedge clk);
    wrStb = 1'b0;
  endtask

  task automatic setMode(logic [1:0] m);
    @(negedge clk);
    modeSel = m;
    @(negedge clk);
  endtask

  task automatic testReset;
    check("R1 valid", {31'd0, rdValid}, 32'd0);
    check("R1 data", rdData, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 valid after release", {31'd0, rdValid}, 32'd0);
    check("R1 data after release", rdData, 32'd0);
  endtask

  task automatic testBright(logic signed [8:0] k, logic [31:0] d);
    logic [31:0] exp;
    setMode(2'd0);
    brightK = k;
    for (int i = 0; i < 4; i++) exp[i*8 +: 8] = brightRef(d[i*8 +: 8], k);
    doWrite(d);
    check("R2 valid", {31'd0, rdValid}, 32'd1);
    check("R2 data", rdData, exp);
  endtask

  task automatic testPair(bit fade, logic [7:0] f, logic [31:0] d0, logic [31:0] d1);
    logic [31:0] prev;
    setMode(fade ? 2'd2 : 2'd1);
    fadeF = f;
    prev = rdData;
    doWrite(d0);
    check("R5 no valid after first half", {31'd0, rdValid}, 32'd0);
    check("R5 data held after first half", rdData, prev);
    doWrite(d1);
    check("R5 valid after second half", {31'd0, rdValid}, 32'd1);
    check(fade ? "R4 fade word" : "R3 blend word", rdData,
          {halfRef(d1, fade, f), halfRef(d0, fade, f)});
  endtask

  task automatic testModeSwitch;
    logic [31:0] a0, b0, b1;
    a0 = 32'hFF10_8020; b0 = 32'h40C0_10F0; b1 = 32'h00FF_FF00;
    setMode(2'd1);
    doWrite(a0);
    setMode(2'd2);
    fadeF = 8'd64;
    doWrite(b0);
    check("R6 switch discards half", {31'd0, rdValid}, 32'd0);
    doWrite(b1);
    check("R6 valid after fresh pair", {31'd0, rdValid}, 32'd1);
    check("R6 word from new mode only", rdData,
          {halfRef(b1, 1'b1, 8'd64), halfRef(b0, 1'b1, 8'd64)});
  endtask

  task automatic testIdleIgnore;
    logic [31:0] prev;
    prev = rdData;
    repeat (3) @(negedge clk);
    check("R7 idle no valid", {31'd0, rdValid}, 32'd0);
    check("R7 idle data held", rdData, prev);
    setMode(2'd3);
    doWrite(32'h1234_5678);
    check("R7 mode 3 no valid", {31'd0, rdValid}, 32'd0);
    check("R7 mode 3 data held", rdData, prev);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testBright(9'sd100, 32'hF0_9B_10_00);
    testBright(-9'sd100, 32'h05_64_65_FF);
    testBright(-9'sd256, 32'hFF_80_01_00);
    testBright(9'sd255, 32'h00_01_7F_FF);
    testPair(1'b0, 8'd0, 32'h80_80_10_20, 32'hFF_01_00_00);
    testPair(1'b0, 8'd0, 32'h7F_80_C8_C8, 32'h01_02_03_04);
    testPair(1'b1, 8'd0, 32'hFF_00_00_FF, 32'h10_20_30_40);
    testPair(1'b1, 8'd128, 32'hFF_00_00_FF, 32'h10_21_C0_40);
    testPair(1'b1, 8'd255, 32'hFF_00_00_FF, 32'h01_02_02_01);
    testModeSwitch();
    testIdleIgnore();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule